// File: doc/BRIEF.md
# Row Cluster Filter and Centroid Encoder

This block takes one row of binary pixel hits each clock cycle and groups neighbouring hits into clusters. A cluster is any maximal run of adjacent set bits. A cluster wider than a run-time width limit is treated as a broad, low-quality track signature and is dropped. For each cluster that survives, the block forms a half-pitch position code. The code is the index of the cluster's lowest pixel plus the index of its highest pixel.

Up to four surviving clusters are reported per row. They appear in four output slots in ascending position order, each slot with its own valid flag. When more clusters survive than there are slots, an overflow flag is raised. Dropped clusters never take a slot and never count towards overflow. One instance serves one row and accepts a new row every cycle. All outputs are registered, so the result for a row appears one clock after the row is presented.

Internally, every pixel position holds two saturating 3-bit run counts: the number of contiguous hits to its left and the number to its right. The left count marks the first pixel of a cluster. At that pixel, the right count gives the cluster width and the position code.

Top module: `rowclu_centroid_enc`

## Requirements
- R1: A cluster is a maximal run of adjacent hit bits in `row_hits`. Two runs separated by at least one clear bit are separate clusters, and a row with no hits produces no valid slot and no overflow.
- R2: A cluster of width W survives only when W <= `max_width`. A cluster of width 8 or more never survives, and `max_width` = 0 drops every cluster.
- R3: The code of a surviving cluster that spans indices s through e is s + e, an 8-bit value from 0 to 238.
- R4: Surviving clusters fill slots 0 upward (slot k is bits [8k+7:8k] of `cent_code` and bit k of `cent_valid`) in ascending position order. At most 4 slots are used.
- R5: `overflow` is 1 exactly when more than 4 clusters survive the width filter. Dropped clusters are not counted.
- R6: A slot whose valid bit is 0 carries code 0.
- R7: The outputs present the result for the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are 0.
- R8: Index 0 and index 119 are row ends. A hit there is bounded by the edge, and runs do not wrap from one end to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_hits | input | 120 | Hit bit per pixel position, bit i is pixel i |
| max_width | input | 3 | Widest cluster kept (0 drops all) |
| cent_code | output | 4x8 | Position codes, slot k at bits [8k+7:8k] |
| cent_valid | output | 4 | Slot valid flags, bit k for slot k |
| overflow | output | 1 | More than 4 clusters survived |

## Verification
Single runs of every width from 1 to 9 are placed at the low edge, the middle and the high edge of the row and swept against every width limit. This separates an off-by-one in the width comparison from an error in the saturating run counts and from mistakes at the row ends. Rows holding exactly four, five, or five clusters of which one is too wide separate the overflow rule from the filter. An alternating pattern and a row that is all hits stress the two extremes of cluster density. Several thousand pseudo-random rows at mixed densities, together with a check of one-cycle latency, cover the interaction of ordering, filtering and slot fill.

// File: rtl/rowclu_pkg.sv
package rowclu_pkg;
   localparam int RC_NPIX_DEF   = 120;
   localparam int RC_CNT_W_DEF  = 3;
   localparam int RC_SLOTS_DEF  = 4;
   localparam int RC_CODE_W_DEF = 8;

   // longest run a CNT_W-bit saturating counter can report
   function automatic int rc_run_max(input int cnt_w);
      return (1 << cnt_w) - 1;
   endfunction

   // largest position code for a row of npix pixels
   function automatic int rc_code_max(input int npix);
      return 2 * (npix - 1);
   endfunction
endpackage

// File: rtl/rowclu_pixel_cell.sv
module rowclu_pixel_cell
   import rowclu_pkg::*;
#(
   parameter int CNT_W  = RC_CNT_W_DEF,
   parameter int CODE_W = RC_CODE_W_DEF,
   parameter int IDX    = 0
) (
   input  logic [2*((1<<CNT_W)-1):0] win,
   input  logic [CNT_W-1:0]          max_width,
   output logic                      keep,
   output logic [CODE_W-1:0]         code
);
   localparam int RUN = rc_run_max(CNT_W);

   logic [CNT_W-1:0] run_l, run_r;
   logic             hit, head, fits;

   assign hit = win[RUN];

   // contiguous hits towards higher indices, saturating at RUN
   always_comb begin
      logic go;
      run_r = '0;
      go    = 1'b1;
      for (int k = 1; k <= RUN; k++) begin
         if (go && win[RUN+k]) run_r = run_r + CNT_W'(1);
         else                  go    = 1'b0;
      end
   end

   // contiguous hits towards lower indices, saturating at RUN
   always_comb begin
      logic go;
      run_l = '0;
      go    = 1'b1;
      for (int k = 1; k <= RUN; k++) begin
         if (go && win[RUN-k]) run_l = run_l + CNT_W'(1);
         else                  go    = 1'b0;
      end
   end

   // a saturated right count means the run is at least RUN+1 wide
   assign head = hit && (run_l == '0);
   assign fits = (run_r != CNT_W'(RUN)) &&
                 ({1'b0, run_r} + (CNT_W+1)'(1) <= {1'b0, max_width});
   assign keep = head && fits;
   assign code = CODE_W'(2 * IDX) + CODE_W'(run_r);
endmodule

// File: rtl/rowclu_pick.sv
module rowclu_pick #(
   parameter int NPIX   = 120,
   parameter int CODE_W = 8
) (
   input  logic [NPIX-1:0]             mask_in,
   input  logic [NPIX-1:0][CODE_W-1:0] codes,
   output logic                        found,
   output logic [CODE_W-1:0]           code,
   output logic [NPIX-1:0]             mask_out
);
   logic [NPIX-1:0] lowest;

   // isolate the lowest set bit with one borrow chain
   assign lowest   = mask_in & ~(mask_in - NPIX'(1));
   assign mask_out = mask_in & ~lowest;
   assign found    = |mask_in;

   always_comb begin
      code = '0;
      for (int j = 0; j < NPIX; j++) begin
         if (lowest[j]) code = code | codes[j];
      end
   end
endmodule

// File: rtl/rowclu_centroid_enc.sv
module rowclu_centroid_enc
   import rowclu_pkg::*;
#(
   parameter int NPIX   = RC_NPIX_DEF,
   parameter int CNT_W  = RC_CNT_W_DEF,
   parameter int SLOTS  = RC_SLOTS_DEF,
   parameter int CODE_W = RC_CODE_W_DEF
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NPIX-1:0]              row_hits,
   input  logic [CNT_W-1:0]             max_width,
   output logic [SLOTS-1:0][CODE_W-1:0] cent_code,
   output logic [SLOTS-1:0]             cent_valid,
   output logic                         overflow
);
   localparam int RUN  = rc_run_max(CNT_W);
   localparam int WINW = 2 * RUN + 1;
   localparam int PADW = NPIX + 2 * RUN;

   generate
      if (NPIX < 2)                               $error("NPIX must be at least 2");
      if (CNT_W < 1)                              $error("CNT_W must be at least 1");
      if (SLOTS < 1 || SLOTS > NPIX)              $error("SLOTS out of range");
      if ((1 << CODE_W) <= rc_code_max(NPIX))     $error("CODE_W too narrow for NPIX");
   endgenerate

   logic [PADW-1:0]             padded;
   logic [NPIX-1:0]             keep_vec;
   logic [NPIX-1:0][CODE_W-1:0] code_vec;
   logic [NPIX-1:0]             mask_chain [SLOTS+1];
   logic [SLOTS-1:0]            nxt_valid;
   logic [SLOTS-1:0][CODE_W-1:0] nxt_code;

   // zero margins make both row ends behave as cluster boundaries
   assign padded = {{RUN{1'b0}}, row_hits, {RUN{1'b0}}};

   generate
      for (genvar i = 0; i < NPIX; i++) begin : g_cell
         rowclu_pixel_cell #(
            .CNT_W (CNT_W),
            .CODE_W(CODE_W),
            .IDX   (i)
         ) u_cell (
            .win      (padded[i +: WINW]),
            .max_width(max_width),
            .keep     (keep_vec[i]),
            .code     (code_vec[i])
         );
      end
   endgenerate

   assign mask_chain[0] = keep_vec;

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         rowclu_pick #(
            .NPIX  (NPIX),
            .CODE_W(CODE_W)
         ) u_pick (
            .mask_in (mask_chain[s]),
            .codes   (code_vec),
            .found   (nxt_valid[s]),
            .code    (nxt_code[s]),
            .mask_out(mask_chain[s+1])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cent_code  <= '0;
         cent_valid <= '0;
         overflow   <= 1'b0;
      end else begin
         cent_code  <= nxt_code;
         cent_valid <= nxt_valid;
         overflow   <= |mask_chain[SLOTS];
      end
   end
endmodule

module rowclu_centroid_enc_chk #(
   parameter int NPIX   = 120,
   parameter int CNT_W  = 3,
   parameter int SLOTS  = 4,
   parameter int CODE_W = 8
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NPIX-1:0]              row_hits,
   input logic [CNT_W-1:0]             max_width,
   input logic [SLOTS-1:0][CODE_W-1:0] cent_code,
   input logic [SLOTS-1:0]             cent_valid,
   input logic                         overflow
);
   localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(2 * (NPIX - 1));

   generate
      for (genvar k = 0; k < SLOTS; k++) begin : g_chk
         AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !cent_valid[k] |-> cent_code[k] == '0); // R6
         AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cent_valid[k] |-> cent_code[k] <= TOP_CODE); // R3
         if (k > 0) begin : g_pair
            AST_SLOTS_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
               cent_valid[k] |-> cent_valid[k-1]); // R4
            AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
               cent_valid[k] |-> cent_code[k] > cent_code[k-1]); // R4
         end
      end
   endgenerate

   AST_OVF_SLOTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> &cent_valid); // R5
   AST_ZERO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(max_width) == '0 |-> (cent_valid == '0 && !overflow)); // R2
   AST_EMPTY_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      $past(row_hits) == '0 |-> (cent_valid == '0 && !overflow)); // R1
endmodule

bind rowclu_centroid_enc rowclu_centroid_enc_chk #(
   .NPIX  (NPIX),
   .CNT_W (CNT_W),
   .SLOTS (SLOTS),
   .CODE_W(CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .row_hits  (row_hits),
   .max_width (max_width),
   .cent_code (cent_code),
   .cent_valid(cent_valid),
   .overflow  (overflow)
);

// File: tb/rowclu_centroid_enc_bench.sv
`timescale 1ns/1ps
module rowclu_centroid_enc_bench;
   localparam int NP = 120;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    row_hits = '0;
   logic [2:0]       max_width = '0;
   logic [3:0][7:0]  cent_code;
   logic [3:0]       cent_valid;
   logic             overflow;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] rng = 32'h1234_5678;

   always #2.5 clk = ~clk;

   rowclu_centroid_enc u_rowclu_centroid_enc (
      .clk(clk), .rst_n(rst_n), .row_hits(row_hits), .max_width(max_width),
      .cent_code(cent_code), .cent_valid(cent_valid), .overflow(overflow)
   );

   // reference: scan runs, filter by width, fill slots in order
   task automatic model(input logic [NP-1:0] h, input int mw,
                        output logic [3:0] v, output logic [3:0][7:0] c, output logic o);
      int n = 0;
      int j = 0;
      v = '0; c = '0;
      while (j < NP) begin
         if (h[j]) begin
            int s = j;
            while (j < NP && h[j]) j++;
            if ((j - s) <= mw) begin
               if (n < 4) begin
                  v[n] = 1'b1;
                  c[n] = 8'(s + (j - 1));
               end
               n++;
            end
         end else begin
            j++;
         end
      end
      o = (n > 4);
   endtask

   task automatic compare(input string tag, input logic [3:0] ev,
                          input logic [3:0][7:0] ec, input logic eo);
      n_cmp++;
      if (cent_valid !== ev || cent_code !== ec || overflow !== eo) begin
         n_bad++;
         $display("FAIL %s: actual v=%b c=%h o=%b expected v=%b c=%h o=%b",
                  tag, cent_valid, cent_code, overflow, ev, ec, eo);
      end
   endtask

   task automatic check_val(input string tag, input int got, input int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic run_vec(input logic [NP-1:0] h, input int mw, input string tag);
      logic [3:0] ev; logic [3:0][7:0] ec; logic eo;
      @(negedge clk);
      row_hits  = h;
      max_width = 3'(mw);
      @(posedge clk);
      #1;
      model(h, mw, ev, ec, eo);
      compare(tag, ev, ec, eo);
   endtask

   function automatic logic [31:0] step(input logic [31:0] x);
      logic [31:0] y = x;
      y ^= y << 13; y ^= y >> 17; y ^= y << 5;
      return y;
   endfunction

   function automatic logic [NP-1:0] run_row(input int s, input int w);
      logic [NP-1:0] r = '0;
      for (int k = 0; k < w; k++) if (s + k < NP) r[s+k] = 1'b1;
      return r;
   endfunction

   initial begin
      logic [NP-1:0] h;
      logic [3:0] ev; logic [3:0][7:0] ec; logic eo;
      repeat (3) @(posedge clk);
      #1;
      compare("R7 reset state", 4'b0, '0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      run_vec('0, 7, "R1 empty row");

      // R8 row ends and R3 extreme codes
      h = '0; h[0] = 1'b1; h[NP-1] = 1'b1;
      run_vec(h, 1, "R8 edge hits");
      check_val("R3 code at index 0", int'(cent_code[0]), 0);
      check_val("R3 code at index 119", int'(cent_code[1]), 238);
      check_val("R8 no wrap between ends", int'(cent_valid), 3);
      h = '0; h[NP-1] = 1'b1; h[NP-2] = 1'b1; h[0] = 1'b1;
      run_vec(h, 2, "R8 top edge pair");
      check_val("R3 top pair code", int'(cent_code[1]), 237);

      // R2 width sweep against every limit at three places
      for (int w = 1; w <= 9; w++)
         for (int mw = 0; mw <= 7; mw++) begin
            run_vec(run_row(0, w), mw, "R2 sweep low");
            run_vec(run_row(37, w), mw, "R2 sweep mid");
            run_vec(run_row(NP - w, w), mw, "R2 sweep high");
         end

      // R1 single gap separates clusters
      h = '0; h[0] = 1; h[1] = 1; h[3] = 1; h[4] = 1;
      run_vec(h, 7, "R1 gap of one");
      check_val("R1 first of split pair", int'(cent_code[0]), 1);
      check_val("R1 second of split pair", int'(cent_code[1]), 7);

      // R5 overflow boundary
      h = '0; for (int k = 0; k < 4; k++) h[10*k] = 1'b1;
      run_vec(h, 7, "R5 exactly four");
      check_val("R5 no overflow at four", int'(overflow), 0);
      h[50] = 1'b1;
      run_vec(h, 7, "R5 five clusters");
      check_val("R5 overflow at five", int'(overflow), 1);
      h = '0; for (int k = 0; k < 4; k++) h[10*k] = 1'b1;
      h = h | run_row(60, 9);
      run_vec(h, 3, "R5 wide cluster not counted");
      check_val("R5 wide cluster no overflow", int'(overflow), 0);

      // R4 dense alternation and R2 full row
      h = '0; for (int k = 0; k < NP; k += 2) h[k] = 1'b1;
      run_vec(h, 1, "R4 alternating");
      check_val("R4 slot 3 code", int'(cent_code[3]), 12);
      run_vec('1, 7, "R2 full row dropped");

      // R7 one-cycle latency: new input not visible before the edge
      run_vec(run_row(20, 3), 7, "R7 first row");
      model(run_row(20, 3), 7, ev, ec, eo);
      @(negedge clk);
      row_hits = run_row(90, 2);
      #1;
      compare("R7 held before edge", ev, ec, eo);
      @(posedge clk);
      #1;
      model(run_row(90, 2), 7, ev, ec, eo);
      compare("R7 after edge", ev, ec, eo);

      // R4 random rows at mixed density
      for (int t = 0; t < 3000; t++) begin
         logic [NP-1:0] a, b;
         for (int q = 0; q < 4; q++) begin
            rng = step(rng); a[q*30 +: 30] = rng[29:0];
            rng = step(rng); b[q*30 +: 30] = rng[29:0];
         end
         case (t % 3)
            0: h = a & b;
            1: h = a;
            default: h = a | b;
         endcase
         run_vec(h, t % 8, "R4 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule